// File: doc/BRIEF.md
# Link Low-Power Entry Acknowledge Responder

This block sits on the receiving side of a serial link and answers the partner's request to put both directions of the link into the low-power L1 state. When a request packet is reported on `rx_l1_req` and the local control field allows L1, the block stops new outbound transactions through `block_tx`. It then offers acknowledge packets on a valid/ready output. It keeps offering them, spaced by a programmable number of idle cycles, until the physical layer reports that the partner has gone electrically idle.

Once idle is seen, the block drops any acknowledge it has not yet handed off and puts its own transmitter into electrical idle. It reports the link as L1. The partner may still see late acknowledges that were already in flight before it went quiet; the block treats that as normal. Either side can end L1. A local `exit_req`, or the partner leaving electrical idle, returns the block to the active state and lifts the transaction block.

The acknowledge output follows valid/ready rules. `ack_valid` stays high until `ack_ready` takes the packet, with one exception: it is withdrawn at once when `rx_eidle` is high. Each accepted acknowledge restarts the spacing count. The downstream packet sender may hold `ack_ready` low for any number of cycles.

Top module: `l1_ack_responder`

## Requirements
- R1: After reset, `link_state` is ACTIVE (2'b00), and `block_tx`, `tx_eidle` and `ack_valid` are all 0.
- R2: A cycle with `rx_l1_req`=1 in ACTIVE while `l1_ctl[1]`=1 moves the block to ACKING (2'b01) at the next edge, with `block_tx`=1. An acknowledge is offered in that first ACKING cycle unless `rx_eidle` is high.
- R3: In ACTIVE, `rx_l1_req` is ignored when `l1_ctl[1]`=0, whatever the value of `l1_ctl[0]`. The state stays ACTIVE and `block_tx` stays 0.
- R4: In ACKING, an accepted acknowledge (valid and ready at an edge) is followed by exactly `ack_gap` cycles with `ack_valid`=0. The offer then returns, so with ready held high the acknowledges are `ack_gap`+1 cycles apart.
- R5: While ACKING and `rx_eidle`=0, a pending acknowledge stays valid until it is accepted.
- R6: `rx_eidle`=1 in ACKING withdraws `ack_valid` in that cycle and moves the block to L1 (2'b10) at the next edge. In L1, `tx_eidle`=1 and `block_tx`=1.
- R7: In L1, `exit_req`=1 or `rx_eidle`=0 returns the block to ACTIVE at the next edge, with `block_tx`=0 and `tx_eidle`=0.
- R8: In ACTIVE, `rx_eidle` and `ack_ready` have no effect: the state stays ACTIVE and no acknowledge is offered. In ACKING, a repeated `rx_l1_req` does not restart the spacing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_ctl | input | 2 | Local low-power control field; bit 1 enables L1 response |
| ack_gap | input | GAP_W | Idle cycles between accepted acknowledges |
| rx_l1_req | input | 1 | Partner L1 request packet received this cycle |
| rx_eidle | input | 1 | Partner electrical idle detected |
| exit_req | input | 1 | Local request to leave L1 |
| ack_valid | output | 1 | Acknowledge packet offered |
| ack_ready | input | 1 | Packet sender accepts the acknowledge |
| block_tx | output | 1 | New outbound transactions are blocked |
| tx_eidle | output | 1 | Local transmitter in electrical idle |
| link_state | output | 2 | 00 ACTIVE, 01 ACKING, 10 L1 |

## Verification
The bench targets the spacing count at a gap of zero and under long back-pressure. A design that reloads the count on the wrong edge, or drops the offer while ready is low, shows the wrong number of quiet cycles. It also drives idle arriving in the same cycle as a pending acknowledge; a design that does not withdraw the offer there hands off a stale acknowledge. Requests are sent with the enable bit clear and only the other control bit set, which a design that decodes the wrong bit would answer. Both exit causes are exercised, and a design that keeps `block_tx` set after exit stalls traffic.

// File: rtl/l1r_pkg.sv
package l1r_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE = 2'b00,
    LS_ACKING = 2'b01,
    LS_L1     = 2'b10
  } link_st_e;

  localparam int unsigned L1_EN_BIT = 1;
endpackage

// File: rtl/l1r_ack_pacer.sv
module l1r_ack_pacer #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             taken,
  input  logic [GAP_W-1:0] gap,
  output logic             due
);
  logic [GAP_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             wait_cnt <= '0;
    else if (!run)          wait_cnt <= '0;
    else if (taken)         wait_cnt <= gap;
    else if (wait_cnt != 0) wait_cnt <= wait_cnt - 1'b1;
  end

  assign due = run && (wait_cnt == '0);
endmodule

// File: rtl/l1r_fsm.sv
module l1r_fsm
  import l1r_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     l1_allowed,
  input  logic     req_seen,
  input  logic     partner_idle,
  input  logic     local_exit,
  output link_st_e state
);
  link_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      LS_ACTIVE: if (req_seen && l1_allowed) nxt = LS_ACKING;
      LS_ACKING: if (partner_idle)           nxt = LS_L1;
      LS_L1:     if (local_exit || !partner_idle) nxt = LS_ACTIVE;
      default:   nxt = LS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LS_ACTIVE;
    else        state <= nxt;
  end
endmodule

// File: rtl/l1_ack_responder.sv
module l1_ack_responder
  import l1r_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       l1_ctl,
  input  logic [GAP_W-1:0] ack_gap,
  input  logic             rx_l1_req,
  input  logic             rx_eidle,
  input  logic             exit_req,
  output logic             ack_valid,
  input  logic             ack_ready,
  output logic             block_tx,
  output logic             tx_eidle,
  output logic [1:0]       link_state
);
  link_st_e st;
  logic     acking;
  logic     ack_due;

  l1r_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .l1_allowed   (l1_ctl[L1_EN_BIT]),
    .req_seen     (rx_l1_req),
    .partner_idle (rx_eidle),
    .local_exit   (exit_req),
    .state        (st)
  );

  assign acking = (st == LS_ACKING);

  l1r_ack_pacer #(.GAP_W(GAP_W)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (acking),
    .taken (ack_valid && ack_ready),
    .gap   (ack_gap),
    .due   (ack_due)
  );

  assign ack_valid  = ack_due && !rx_eidle;
  assign block_tx   = (st != LS_ACTIVE);
  assign tx_eidle   = (st == LS_L1);
  assign link_state = st;
endmodule

// File: rtl/l1r_checker.sv
module l1r_checker #(
  parameter int unsigned GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       l1_ctl,
  input logic [GAP_W-1:0] ack_gap,
  input logic             rx_l1_req,
  input logic             rx_eidle,
  input logic             exit_req,
  input logic             ack_valid,
  input logic             ack_ready,
  input logic             block_tx,
  input logic             tx_eidle,
  input logic [1:0]       link_state
);
  p_block_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'b00 && rx_l1_req && l1_ctl[1]) |=> (block_tx && link_state == 2'b01));

  p_ignore_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'b00 && !l1_ctl[1]) |=> (link_state == 2'b00 && !block_tx));

  p_quiet_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && ack_gap != '0) |=> !ack_valid);

  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid || rx_eidle));

  p_enter_l1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'b01 && rx_eidle) |=> (link_state == 2'b10 && tx_eidle && block_tx));

  p_no_ack_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eidle |-> !ack_valid);

  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'b10 && (exit_req || !rx_eidle)) |=> (link_state == 2'b00 && !block_tx && !tx_eidle));

  p_ack_only_acking_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (link_state == 2'b01));
endmodule

bind l1_ack_responder l1r_checker #(.GAP_W(GAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .l1_ctl     (l1_ctl),
  .ack_gap    (ack_gap),
  .rx_l1_req  (rx_l1_req),
  .rx_eidle   (rx_eidle),
  .exit_req   (exit_req),
  .ack_valid  (ack_valid),
  .ack_ready  (ack_ready),
  .block_tx   (block_tx),
  .tx_eidle   (tx_eidle),
  .link_state (link_state)
);

// File: tb/sim_l1_ack_responder.sv
`timescale 1ns/1ps
module sim_l1_ack_responder;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    l1_ctl = 2'b00;
  logic [GW-1:0] ack_gap = '0;
  logic          rx_l1_req = 1'b0;
  logic          rx_eidle = 1'b0;
  logic          exit_req = 1'b0;
  logic          ack_ready = 1'b0;
  logic          ack_valid, block_tx, tx_eidle;
  logic [1:0]    link_state;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  l1_ack_responder #(.GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .l1_ctl(l1_ctl), .ack_gap(ack_gap),
    .rx_l1_req(rx_l1_req), .rx_eidle(rx_eidle), .exit_req(exit_req),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .block_tx(block_tx),
    .tx_eidle(tx_eidle), .link_state(link_state)
  );

  // Reference model built from the requirements
  logic [1:0]    m_st = 2'b00;
  logic [GW-1:0] m_gap = '0;
  string         m_tag = "R1";

  function automatic bit exp_vld();
    return (m_st == 2'b01) && (m_gap == '0) && !rx_eidle;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 2'b00; m_gap <= '0; m_tag <= "R1";
    end else begin
      case (m_st)
        2'b00: begin
          if (rx_l1_req && l1_ctl[1]) begin m_st <= 2'b01; m_gap <= '0; m_tag <= "R2"; end
          else if (rx_l1_req) m_tag <= "R3";
          else m_tag <= "R8";
        end
        2'b01: begin
          if (rx_eidle) begin m_st <= 2'b10; m_gap <= '0; m_tag <= "R6"; end
          else if (exp_vld() && ack_ready) begin m_gap <= ack_gap; m_tag <= "R4"; end
          else begin
            if (m_gap != '0) m_gap <= m_gap - 1'b1;
            m_tag <= exp_vld() ? "R5" : (rx_l1_req ? "R8" : "R4");
          end
        end
        default: begin
          if (exit_req || !rx_eidle) begin m_st <= 2'b00; m_tag <= "R7"; end
          else m_tag <= "R6";
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(link_state == m_st, m_tag, "link_state", link_state, m_st);
    chk(block_tx == (m_st != 2'b00), m_tag, "block_tx", block_tx, m_st != 2'b00);
    chk(tx_eidle == (m_st == 2'b10), m_tag, "tx_eidle", tx_eidle, m_st == 2'b10);
    chk(ack_valid == exp_vld(), m_tag, "ack_valid", ack_valid, exp_vld());
  endtask

  task automatic step(input bit req, input bit eid, input bit ex, input bit rdy);
    @(negedge clk);
    compare_all();
    rx_l1_req = req; rx_eidle = eid; exit_req = ex; ack_ready = rdy;
  endtask

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(link_state == 2'b00, "R1", "link_state", link_state, 0);
    chk(!block_tx && !tx_eidle && !ack_valid, "R1", "outputs", {block_tx, tx_eidle, ack_valid}, 0);
    rst_n = 1'b1;

    // R3: only bit 0 set, request ignored
    l1_ctl = 2'b01; ack_gap = 8'd3;
    step(1, 0, 0, 1); step(0, 1, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    // R2, R4: enable, request, acknowledges spaced by gap
    l1_ctl = 2'b10;
    step(1, 0, 0, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1);
    // R8: repeat request while acking
    step(1, 0, 0, 1); step(0, 0, 0, 1);
    // R5: back-pressure
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0);
    // R6: idle while offer pending
    step(0, 1, 0, 0); step(0, 1, 0, 1); step(0, 1, 0, 1);
    // R7: local exit
    step(0, 1, 1, 1); step(0, 0, 0, 1);
    // gap zero, then partner-driven exit
    ack_gap = '0; l1_ctl = 2'b11;
    step(1, 0, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
    step(0, 1, 0, 1); step(0, 1, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      bit eid;
      if (i % 200 == 0) begin
        ack_gap = GW'($urandom_range(0, 6));
        l1_ctl = 2'($urandom_range(0, 3));
      end
      eid = ($urandom_range(0, 11) == 0) ? !rx_eidle : rx_eidle;
      step($urandom_range(0, 7) == 0, eid, $urandom_range(0, 15) == 0,
           $urandom_range(0, 3) != 0);
    end
    step(0, 0, 0, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule